// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block sits between raw interrupt sources and a parent interrupt controller. It accepts eight dedicated interrupt pins, one non-maskable line and a 128-line GPIO interrupt bus. Thirty-two GPIO channels each pick one line from that bus through a programmable 7-bit index. Every dedicated line and every GPIO channel passes through a two-flop synchronizer. Each then uses a 2-bit sense field to choose low-level, falling-edge, rising-edge or both-edge detection. The result drives an active-high level toward the parent controller.

In an edge mode a detected edge sets a status bit, and that bit holds the output high until software clears it. Software clears a bit by writing 0 to it, and only when the bit is set and the source is in an edge mode. Every other status write is dropped without effect. In low-level mode the status bit simply mirrors the synchronized input being low. The sense and source-select registers can be written and read back on their own, so interrupt types can be restored in any order relative to the source selection.

Top module: `eic_top`

## Requirements
- R1: After reset every register reads 0, line_irq_o and gpio_irq_o are 0 while all inputs are high, and nmi_o is 0.
- R2: Sense field of dedicated line k is bits [2k+1:2k] at offset 0x14 (upper 16 bits read 0). GPIO channel j uses bits [2(j mod 16)+1:2(j mod 16)] at offset 0x24 for j<16 and at 0x28 otherwise. The encoding is 00 low level, 01 falling, 10 rising, 11 both edges. These registers read back what was written.
- R3: In low-level mode, status bit k at 0x10 (or bit j at 0x20 for GPIO channels) and the matching output equal the inverse of the input, two clock edges after the input changes.
- R4: In falling-edge mode a high-to-low input transition sets the status bit, and the bit stays set after the input returns high.
- R5: In rising-edge mode only a low-to-high transition sets the status bit. A high-to-low transition leaves it at 0.
- R6: In both-edge mode either transition sets the status bit.
- R7: In an edge mode, writing 0 to a set status bit clears it. Writing 1 to it leaves it set.
- R8: While a source is in low-level mode, writes to its status bit are ignored and the bit keeps following the input.
- R9: An edge detected in the same cycle as a clearing write leaves the status bit set.
- R10: GPIO channel j takes gpio_int_i[idx]. The 7-bit idx sits in bits [8(j mod 4)+6:8(j mod 4)] of offset 0x30+4*(j div 4), and bit 7 of each byte reads 0.
- R11: nmi_o equals nmi_i delayed by two clock edges.
- R12: Reads of unmapped or misaligned offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register, same cycle |
| irq_pin_i | input | 8 | Dedicated interrupt pins |
| gpio_int_i | input | 128 | GPIO interrupt bus |
| nmi_i | input | 1 | Non-maskable interrupt input |
| line_irq_o | output | 8 | Level outputs of the dedicated lines |
| gpio_irq_o | output | 32 | Level outputs of the GPIO channels |
| nmi_o | output | 1 | Synchronized non-maskable interrupt |

## Verification
Each sense mode gets its own line and its own pin waveform: a single fall, a fall then a rise, and a rise with no preceding latch. Together these separate falling, rising and both-edge detection from plain level following. Clearing writes of all-ones, of 0 to a level-mode bit, and of 0 to a set edge bit show that only the last of these has any effect. A clear placed exactly in the cycle a new edge is detected shows the priority of the edge. GPIO channels are pointed at bus lines 5, 42 and 127, so a wrong select field or a wrong mode-register half shows up as the wrong output bit.

// File: rtl/eic_pkg.sv
package eic_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int unsigned OFS_LINE_STAT = 32'h10;
  localparam int unsigned OFS_LINE_MODE = 32'h14;
  localparam int unsigned OFS_GCH_STAT  = 32'h20;
  localparam int unsigned OFS_GCH_MODE  = 32'h24;
  localparam int unsigned OFS_GCH_SEL   = 32'h30;

  localparam int unsigned MODE_PER_REG = 16;
  localparam int unsigned SEL_PER_REG  = 4;
  localparam int unsigned SEL_LANE     = 8;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/eic_chan.sv
module eic_chan
  import eic_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       raw_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       stat_o
);
  sense_e mode;
  logic   lvl, prev_q, hold_q, hit;

  assign mode = sense_e'(mode_i);

  // idle high so level-low mode is quiet out of reset
  eic_sync #(.W(1), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (lvl)
  );

  always_comb begin
    unique case (mode)
      SENSE_FALL: hit = prev_q & ~lvl;
      SENSE_RISE: hit = ~prev_q & lvl;
      SENSE_BOTH: hit = prev_q ^ lvl;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (mode == SENSE_LOW)      hold_q <= 1'b0;
      else if (hit)               hold_q <= 1'b1;  // edge beats clear
      else if (clr_i && hold_q)   hold_q <= 1'b0;
    end
  end

  assign stat_o = (mode == SENSE_LOW) ? ~lvl : hold_q;
endmodule

// File: rtl/eic_src_mux.sv
module eic_src_mux #(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned N_SRC = 128,
  parameter int unsigned SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]            src_i,
  input  logic [N_CH-1:0][SEL_W-1:0]  sel_i,
  output logic [N_CH-1:0]             ch_o
);
  for (genvar j = 0; j < N_CH; j++) begin : g_ch
    assign ch_o[j] = src_i[sel_i[j]];
  end
endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int unsigned N_LINE = 8,
  parameter int unsigned N_GCH  = 32,
  parameter int unsigned N_GPIO = 128,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_LINE-1:0] irq_pin_i,
  input  logic [N_GPIO-1:0] gpio_int_i,
  input  logic              nmi_i,
  output logic [N_LINE-1:0] line_irq_o,
  output logic [N_GCH-1:0]  gpio_irq_o,
  output logic              nmi_o
);
  localparam int unsigned SEL_W      = $clog2(N_GPIO);
  localparam int unsigned MODE_BITS  = 2 * MODE_PER_REG;
  localparam int unsigned N_MODE_REG = N_GCH / MODE_PER_REG;
  localparam int unsigned N_SEL_REG  = N_GCH / SEL_PER_REG;

  function automatic logic at_ofs(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic [2*N_LINE-1:0]           line_mode_q;
  logic [2*N_GCH-1:0]            gch_mode_q;
  logic [N_GCH-1:0][SEL_W-1:0]   sel_q;
  logic [N_LINE-1:0]             line_clr;
  logic [N_GCH-1:0]              gch_clr, gch_raw;
  logic                          wr;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_mode_q <= '0;
      gch_mode_q  <= '0;
      sel_q       <= '0;
    end else if (wr) begin
      if (at_ofs(addr_i, OFS_LINE_MODE)) line_mode_q <= wdata_i[2*N_LINE-1:0];
      for (int n = 0; n < N_MODE_REG; n++) begin
        if (at_ofs(addr_i, OFS_GCH_MODE + 4 * n))
          gch_mode_q[n*MODE_BITS +: MODE_BITS] <= wdata_i[MODE_BITS-1:0];
      end
      for (int r = 0; r < N_SEL_REG; r++) begin
        if (at_ofs(addr_i, OFS_GCH_SEL + 4 * r)) begin
          for (int b = 0; b < SEL_PER_REG; b++)
            sel_q[r*SEL_PER_REG+b] <= wdata_i[b*SEL_LANE +: SEL_W];
        end
      end
    end
  end

  // write-zero clear requests; channel applies the mode/state rules
  always_comb begin
    line_clr = (wr && at_ofs(addr_i, OFS_LINE_STAT)) ? ~wdata_i[N_LINE-1:0] : '0;
    gch_clr  = (wr && at_ofs(addr_i, OFS_GCH_STAT))  ? ~wdata_i[N_GCH-1:0]  : '0;
  end

  for (genvar k = 0; k < N_LINE; k++) begin : g_line
    eic_chan u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (irq_pin_i[k]),
      .mode_i(line_mode_q[2*k +: 2]),
      .clr_i (line_clr[k]),
      .stat_o(line_irq_o[k])
    );
  end

  eic_src_mux #(.N_CH(N_GCH), .N_SRC(N_GPIO), .SEL_W(SEL_W)) u_mux (
    .src_i(gpio_int_i),
    .sel_i(sel_q),
    .ch_o (gch_raw)
  );

  for (genvar j = 0; j < N_GCH; j++) begin : g_gch
    eic_chan u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (gch_raw[j]),
      .mode_i(gch_mode_q[2*j +: 2]),
      .clr_i (gch_clr[j]),
      .stat_o(gpio_irq_o[j])
    );
  end

  eic_sync #(.W(1), .RST_VAL(1'b0)) u_nmi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (nmi_i),
    .q_o   (nmi_o)
  );

  always_comb begin
    rdata_o = '0;
    if (at_ofs(addr_i, OFS_LINE_STAT)) rdata_o[N_LINE-1:0]   = line_irq_o;
    if (at_ofs(addr_i, OFS_LINE_MODE)) rdata_o[2*N_LINE-1:0] = line_mode_q;
    if (at_ofs(addr_i, OFS_GCH_STAT))  rdata_o[N_GCH-1:0]    = gpio_irq_o;
    for (int n = 0; n < N_MODE_REG; n++) begin
      if (at_ofs(addr_i, OFS_GCH_MODE + 4 * n))
        rdata_o[MODE_BITS-1:0] = gch_mode_q[n*MODE_BITS +: MODE_BITS];
    end
    for (int r = 0; r < N_SEL_REG; r++) begin
      if (at_ofs(addr_i, OFS_GCH_SEL + 4 * r)) begin
        for (int b = 0; b < SEL_PER_REG; b++)
          rdata_o[b*SEL_LANE +: SEL_W] = sel_q[r*SEL_PER_REG+b];
      end
    end
  end
endmodule

// File: rtl/eic_checker.sv
module eic_checker
  import eic_pkg::*;
#(
  parameter int unsigned N_LINE    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned N_SEL_REG = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_LINE-1:0] wdata_lo,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_LINE-1:0] irq_pin_i,
  input logic              nmi_i,
  input logic [N_LINE-1:0] line_irq_o,
  input logic              nmi_o,
  input logic [2*N_LINE-1:0] line_mode
);
  logic [1:0] age_q;
  logic       stat_wr, mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  assign stat_wr = req_i && we_i && (addr_i == ADDR_W'(OFS_LINE_STAT));

  always_comb begin
    mapped = (addr_i == ADDR_W'(OFS_LINE_STAT)) || (addr_i == ADDR_W'(OFS_LINE_MODE)) ||
             (addr_i == ADDR_W'(OFS_GCH_STAT))  || (addr_i == ADDR_W'(OFS_GCH_MODE)) ||
             (addr_i == ADDR_W'(OFS_GCH_MODE + 4));
    for (int r = 0; r < N_SEL_REG; r++)
      if (addr_i == ADDR_W'(OFS_GCH_SEL + 4 * r)) mapped = 1'b1;
  end

  a_r12_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !mapped) |-> (rdata_o == '0));

  a_r11_nmi_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (nmi_o == $past(nmi_i, 2)));

  for (genvar k = 0; k < N_LINE; k++) begin : g_k
    a_r3_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2 && line_mode[2*k +: 2] == 2'b00) |-> (line_irq_o[k] == !$past(irq_pin_i[k], 2)));

    a_r7_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(line_mode[2*k +: 2]) != 2'b00 && line_mode[2*k +: 2] != 2'b00 && $fell(line_irq_o[k]))
      |-> $past(stat_wr && !wdata_lo[k]));

    a_r4_edge_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(line_mode[2*k +: 2]) != 2'b00 && line_mode[2*k +: 2] != 2'b00 &&
       $past(line_irq_o[k]) && !$past(stat_wr)) |-> line_irq_o[k]);
  end
endmodule

bind eic_top eic_checker #(
  .N_LINE(N_LINE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SEL_REG(N_SEL_REG)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_lo  (wdata_i[N_LINE-1:0]),
  .rdata_o   (rdata_o),
  .irq_pin_i (irq_pin_i),
  .nmi_i     (nmi_i),
  .line_irq_o(line_irq_o),
  .nmi_o     (nmi_o),
  .line_mode (line_mode_q)
);

// File: tb/eic_top_tb_top.sv
`timescale 1ns/1ps
module eic_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0, rdata;
  logic [7:0]   pins = 8'hFF;
  logic [127:0] gpio = '1;
  logic         nmi = 1'b0;
  logic [7:0]   line_irq;
  logic [31:0]  gpio_irq;
  logic         nmi_q;

  always #4 clk = ~clk;  // 125 MHz

  eic_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_pin_i(pins), .gpio_int_i(gpio),
    .nmi_i(nmi), .line_irq_o(line_irq), .gpio_irq_o(gpio_irq), .nmi_o(nmi_q)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;

  // monitor: pops expected items and compares with the sampled output
  initial begin : mon
    item_t       it;
    logic [31:0] got;
    forever begin
      wait (q.size() > 0);
      #1;
      it = q.pop_front();
      case (it.sel)
        0:       got = rdata;
        1:       got = {24'h0, line_irq};
        2:       got = gpio_irq;
        default: got = {31'h0, nmi_q};
      endcase
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic push_exp(input int sel, input logic [31:0] e, input string tag);
    item_t it;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    #2;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    push_exp(0, e, tag);
    req = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic out(input int sel, input logic [31:0] e, input string tag);
    @(negedge clk);
    push_exp(sel, e, tag);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : drv
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(8'h10, 32'h0, "R1 line status");
    rd(8'h14, 32'h0, "R1 line mode");
    rd(8'h20, 32'h0, "R1 gpio status");
    rd(8'h24, 32'h0, "R1 gpio mode0");
    rd(8'h28, 32'h0, "R1 gpio mode1");
    rd(8'h30, 32'h0, "R1 select0");
    rd(8'h4C, 32'h0, "R1 select7");
    out(1, 32'h0, "R1 line_irq_o");
    out(2, 32'h0, "R1 gpio_irq_o");
    out(3, 32'h0, "R1 nmi_o");

    // R2 mode registers: line0 both, line1/2 level, line3 both, line4/5 fall, line6/7 rise
    wr(8'h14, 32'hFFFF_A5C3);
    rd(8'h14, 32'h0000_A5C3, "R2 line mode readback");
    wr(8'h24, 32'h1234_5678);
    rd(8'h24, 32'h1234_5678, "R2 gpio mode0 readback");
    wr(8'h28, 32'h9ABC_DEF0);
    rd(8'h28, 32'h9ABC_DEF0, "R2 gpio mode1 readback");
    rd(8'h10, 32'h0, "R2 no status from mode write");

    // R3 / R8 level mode on line1
    @(negedge clk) pins[1] = 1'b0;
    @(posedge clk);
    out(1, 32'h0, "R3 one edge not yet visible");
    out(1, 32'h02, "R3 level low after two edges");
    rd(8'h10, 32'h02, "R3 status follows level");
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h02, "R8 clear ignored in level mode");
    @(negedge clk) pins[1] = 1'b1;
    settle();
    out(1, 32'h0, "R3 level released");

    // R4 / R7 falling edge on line4
    @(negedge clk) pins[4] = 1'b0;
    settle();
    out(1, 32'h10, "R4 falling edge latched");
    @(negedge clk) pins[4] = 1'b1;
    settle();
    out(1, 32'h10, "R4 holds after input high");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h10, "R7 write one keeps bit");
    wr(8'h10, 32'hFFFF_FFEF);
    rd(8'h10, 32'h0, "R7 write zero clears");

    // R5 rising edge on line6
    @(negedge clk) pins[6] = 1'b0;
    settle();
    out(1, 32'h0, "R5 falling ignored");
    @(negedge clk) pins[6] = 1'b1;
    settle();
    out(1, 32'h40, "R5 rising latched");
    wr(8'h10, 32'hFFFF_FFBF);
    out(1, 32'h0, "R5 cleared");

    // R6 both edges on line0
    @(negedge clk) pins[0] = 1'b0;
    settle();
    out(1, 32'h01, "R6 fall latched");
    wr(8'h10, 32'hFFFF_FFFE);
    settle();
    out(1, 32'h0, "R6 cleared while low");
    @(negedge clk) pins[0] = 1'b1;
    settle();
    out(1, 32'h01, "R6 rise latched");
    wr(8'h10, 32'hFFFF_FFFE);
    out(1, 32'h0, "R6 cleared");

    // R9 edge and clear in same cycle on line0
    @(negedge clk) pins[0] = 1'b0;
    settle();
    out(1, 32'h01, "R9 set by fall");
    @(negedge clk) pins[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    wr(8'h10, 32'hFFFF_FFFE);
    out(1, 32'h01, "R9 edge wins over clear");
    wr(8'h10, 32'hFFFF_FFFE);
    out(1, 32'h0, "R9 later clear works");

    // R10 source select
    wr(8'h24, 32'h0);
    wr(8'h28, 32'h0);
    wr(8'h30, 32'hFF85_057F);
    rd(8'h30, 32'h7F05_057F, "R10 select readback");
    @(negedge clk) gpio[127] = 1'b0;
    settle();
    out(2, 32'h0000_0009, "R10 ch0/ch3 from line 127");
    rd(8'h20, 32'h0000_0009, "R3 gpio level status");
    @(negedge clk) begin gpio[127] = 1'b1; gpio[5] = 1'b0; end
    settle();
    out(2, 32'h0000_0006, "R10 ch1/ch2 from line 5");
    @(negedge clk) gpio[5] = 1'b1;
    wr(8'h4C, 32'h2A00_0000);
    wr(8'h28, 32'h4000_0000);
    settle();
    out(2, 32'h0, "R10 quiet before edge");
    @(negedge clk) gpio[42] = 1'b0;
    settle();
    @(negedge clk) gpio[42] = 1'b1;
    settle();
    out(2, 32'h8000_0000, "R4 ch31 falling via line 42");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h8000_0000, "R7 gpio write one keeps");
    wr(8'h20, 32'h7FFF_FFFF);
    rd(8'h20, 32'h0, "R7 gpio clear");

    // R11 nmi
    @(negedge clk) nmi = 1'b1;
    push_exp(3, 32'h0, "R11 nmi before edges");
    @(posedge clk);
    out(3, 32'h0, "R11 nmi after one edge");
    out(3, 32'h1, "R11 nmi after two edges");
    @(negedge clk) nmi = 1'b0;
    settle();
    out(3, 32'h0, "R11 nmi released");

    // R12 unmapped offsets
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0, "R12 unmapped read");
    rd(8'h50, 32'h0, "R12 past select regs");
    rd(8'h12, 32'h0, "R12 misaligned");
    rd(8'h14, 32'h0000_A5C3, "R12 mode unchanged");
    rd(8'h4C, 32'h2A00_0000, "R12 select unchanged");

    wait (q.size() == 0);
    #5;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule